// File: doc/BRIEF.md
# Dual-Word Serial Control Loader

This block accepts two configuration words for a frequency synthesizer over a slow three-wire style serial link. A single serial clock is shared by two data lines, and each data line has its own latch line. The coarse word is 30 bits and is unpacked into seven named fields. The fine word is a flat 32-bit tuning value. Serial bits first collect in a shadow shift register for each word. They reach the parallel holding registers only when the matching latch line rises.

All five serial lines are asynchronous to the fast system clock. Each line passes through a two-flop synchroniser, and rising edges are found in the system clock domain. The system clock must run at least eight times faster than the serial clock. The serial clock itself runs at 1 MHz or below. Downstream logic reads the holding registers. It can use the one-cycle update strobe of each word to learn that a new value has arrived. Range checking of the fields and all frequency arithmetic belong to the logic that consumes these outputs.

Top module: `dualword_serial_loader`

## Requirements
- R1: While reset is asserted and after its release, every holding output reads zero and both update strobes stay low until a latch rises.
- R2: Coarse bits are shifted in on each serial clock rise. Each field is sent most significant bit first, in the field order k(4), m(4), t(4), f(4), n(8), r(5), and finally the single polarity bit. Once 30 bits have been shifted, the first bit sent is k[3] and the last bit sent is the polarity bit.
- R3: A coarse holding output changes only in the cycle after a rising edge of the coarse latch. Shifting without a latch leaves the outputs unchanged.
- R4: While the coarse latch is high, serial clock rises do not shift the coarse shadow register. A later latch with no clocks in between reloads the same coarse value.
- R5: The fine word is shifted most significant bit first. A rise of the fine latch transfers all 32 bits to the fine output.
- R6: Each latch rise produces exactly one update strobe of one system cycle on the matching word's strobe, and no strobe on the other word's strobe.
- R7: The two words share one serial clock but are latched independently. Latching one word never alters the other word's holding outputs.
- R8: When more bits are shifted than a word holds, the word keeps the most recent bits. For the coarse word, that is the last 30 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Shared serial clock, sampled on rising edges |
| crs_din | input | 1 | Coarse word serial data |
| crs_ld | input | 1 | Coarse latch; its rise transfers, and while high it freezes shifting |
| fin_din | input | 1 | Fine word serial data |
| fin_ld | input | 1 | Fine latch; its rise transfers |
| k_fld | output | 4 | Coarse field k |
| m_fld | output | 4 | Coarse field m |
| t_fld | output | 4 | Coarse field t |
| f_fld | output | 4 | Coarse field f |
| n_fld | output | 8 | Coarse field n |
| r_fld | output | 5 | Coarse field r |
| pol_fld | output | 1 | Coarse polarity bit |
| fine_word | output | 32 | Fine tuning word |
| crs_upd | output | 1 | One-cycle pulse when the coarse fields update |
| fin_upd | output | 1 | One-cycle pulse when the fine word updates |

## Verification
Both data lines are driven together under the shared clock for 32 serial clocks. The coarse line carries two junk leading bits, so every transfer also tests that only the newest 30 bits are kept. The patterns are all-zero, all-one, alternating, walking-ones per field and a multiplicative hash sweep. A field swap or a reversed bit order fails the alternating and walking-field patterns, while the all-ones pattern shows stuck bits. Reading the outputs before each latch and after the other word's latch separates early transfer from cross-word coupling. A latch that is held high while clocks keep running, followed by a second latch, separates a frozen shifter from one that still moves.

// File: rtl/ser_ld_pkg.sv
package ser_ld_pkg;
  localparam int K_W    = 4;
  localparam int M_W    = 4;
  localparam int T_W    = 4;
  localparam int F_W    = 4;
  localparam int N_W    = 8;
  localparam int R_W    = 5;
  localparam int P_W    = 1;
  localparam int CRS_W  = K_W + M_W + T_W + F_W + N_W + R_W + P_W;
  localparam int FINE_W = 32;

  // first field sent sits at the top of the shifted word
  typedef struct packed {
    logic [K_W-1:0] k;
    logic [M_W-1:0] m;
    logic [T_W-1:0] t;
    logic [F_W-1:0] f;
    logic [N_W-1:0] n;
    logic [R_W-1:0] r;
    logic [P_W-1:0] p;
  } crs_word_t;
endpackage

// File: rtl/ser_ld_sync.sv
module ser_ld_sync #(
  parameter int LINES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o
);
  logic [LINES-1:0] s1_q, s2_q, s3_q;

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1_q[g] <= 1'b0;
          s2_q[g] <= 1'b0;
          s3_q[g] <= 1'b0;
        end else begin
          s1_q[g] <= raw_i[g];
          s2_q[g] <= s1_q[g];
          s3_q[g] <= s2_q[g];
        end
      end

      assign lvl_o[g]  = s2_q[g];
      assign rise_o[g] = s2_q[g] & ~s3_q[g];

      // R6
      rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o[g] |=> !rise_o[g]);
    end
  endgenerate
endmodule

// File: rtl/ser_ld_shreg.sv
module ser_ld_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         freeze_i,
  input  logic         bit_i,
  input  logic         load_i,
  output logic [W-1:0] hold_o,
  output logic         upd_o
);
  logic [W-1:0] shadow_q, shadow_d;
  logic [W-1:0] hold_q, hold_d;
  logic         upd_q, upd_d;
  logic         shift_en;

  assign shift_en = step_i & ~freeze_i;

  always_comb begin
    shadow_d = shadow_q;
    if (shift_en) shadow_d = {shadow_q[W-2:0], bit_i};
    hold_d = hold_q;
    if (load_i) hold_d = shadow_q;
    upd_d = load_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      hold_q   <= '0;
      upd_q    <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      hold_q   <= hold_d;
      upd_q    <= upd_d;
    end
  end

  assign hold_o = hold_q;
  assign upd_o  = upd_q;

  // R6
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);
  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> $stable(hold_o));
  // R4
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |=> $stable(shadow_q));
endmodule

// File: rtl/dualword_serial_loader.sv
module dualword_serial_loader
  import ser_ld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              crs_din,
  input  logic              crs_ld,
  input  logic              fin_din,
  input  logic              fin_ld,
  output logic [K_W-1:0]    k_fld,
  output logic [M_W-1:0]    m_fld,
  output logic [T_W-1:0]    t_fld,
  output logic [F_W-1:0]    f_fld,
  output logic [N_W-1:0]    n_fld,
  output logic [R_W-1:0]    r_fld,
  output logic              pol_fld,
  output logic [FINE_W-1:0] fine_word,
  output logic              crs_upd,
  output logic              fin_upd
);
  localparam int NLINE = 5;
  localparam int I_SCK = 0;
  localparam int I_CD  = 1;
  localparam int I_CL  = 2;
  localparam int I_FD  = 3;
  localparam int I_FL  = 4;

  logic [NLINE-1:0] raw, lvl, rise;
  logic [CRS_W-1:0] crs_hold;
  crs_word_t        crs_flds;

  assign raw = {fin_ld, fin_din, crs_ld, crs_din, ser_clk};

  ser_ld_sync #(.LINES(NLINE)) sync_i (
    .clk(clk), .rst_n(rst_n), .raw_i(raw), .lvl_o(lvl), .rise_o(rise)
  );

  ser_ld_shreg #(.W(CRS_W)) crs_i (
    .clk(clk), .rst_n(rst_n),
    .step_i(rise[I_SCK]), .freeze_i(lvl[I_CL]),
    .bit_i(lvl[I_CD]), .load_i(rise[I_CL]),
    .hold_o(crs_hold), .upd_o(crs_upd)
  );

  ser_ld_shreg #(.W(FINE_W)) fin_i (
    .clk(clk), .rst_n(rst_n),
    .step_i(rise[I_SCK]), .freeze_i(1'b0),
    .bit_i(lvl[I_FD]), .load_i(rise[I_FL]),
    .hold_o(fine_word), .upd_o(fin_upd)
  );

  assign crs_flds = crs_word_t'(crs_hold);
  assign k_fld    = crs_flds.k;
  assign m_fld    = crs_flds.m;
  assign t_fld    = crs_flds.t;
  assign f_fld    = crs_flds.f;
  assign n_fld    = crs_flds.n;
  assign r_fld    = crs_flds.r;
  assign pol_fld  = crs_flds.p[0];
endmodule

// File: tb/dualword_serial_loader_tb_top.sv
module dualword_serial_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, crs_din = 1'b0, crs_ld = 1'b0, fin_din = 1'b0, fin_ld = 1'b0;
  logic [3:0] k_fld, m_fld, t_fld, f_fld;
  logic [7:0] n_fld;
  logic [4:0] r_fld;
  logic pol_fld;
  logic [31:0] fine_word;
  logic crs_upd, fin_upd;

  int checks = 0, errors = 0;
  int n_cu = 0, n_fu = 0;
  logic [29:0] exp_c = '0;
  logic [31:0] exp_f = '0;

  always #4 clk = ~clk;

  dualword_serial_loader dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .crs_din(crs_din), .crs_ld(crs_ld),
    .fin_din(fin_din), .fin_ld(fin_ld), .k_fld(k_fld), .m_fld(m_fld), .t_fld(t_fld),
    .f_fld(f_fld), .n_fld(n_fld), .r_fld(r_fld), .pol_fld(pol_fld),
    .fine_word(fine_word), .crs_upd(crs_upd), .fin_upd(fin_upd)
  );

  always @(negedge clk) begin
    if (crs_upd) n_cu++;
    if (fin_upd) n_fu++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [29:0] crs_out();
    return {k_fld, m_fld, t_fld, f_fld, n_fld, r_fld, pol_fld};
  endfunction

  // 32 shared serial clocks: coarse line leads with two junk ones
  task automatic shift_pair(input logic [29:0] c, input logic [31:0] f);
    for (int b = 31; b >= 0; b--) begin
      crs_din = (b >= 30) ? 1'b1 : c[b];
      fin_din = f[b];
      wclk(10);
      ser_clk = 1'b1;
      wclk(10);
      ser_clk = 1'b0;
    end
  endtask

  task automatic pulse_ld(input bit coarse);
    if (coarse) crs_ld = 1'b1; else fin_ld = 1'b1;
    wclk(10);
    if (coarse) crs_ld = 1'b0; else fin_ld = 1'b0;
    wclk(10);
  endtask

  task automatic run_word(input logic [29:0] c, input logic [31:0] f);
    shift_pair(c, f);
    chk("R3 coarse before latch", crs_out(), exp_c);
    chk("R5 fine before latch", fine_word, exp_f);
    n_cu = 0; n_fu = 0;
    pulse_ld(1'b1);
    exp_c = c;
    chk("R2 k", k_fld, c[29:26]);
    chk("R2 m", m_fld, c[25:22]);
    chk("R2 t", t_fld, c[21:18]);
    chk("R2 f", f_fld, c[17:14]);
    chk("R2 n", n_fld, c[13:6]);
    chk("R2 r", r_fld, c[5:1]);
    chk("R8 pol last bit", pol_fld, c[0]);
    chk("R7 fine kept", fine_word, exp_f);
    chk("R6 coarse strobes", n_cu, 1);
    chk("R6 no fine strobe", n_fu, 0);
    n_cu = 0; n_fu = 0;
    pulse_ld(1'b0);
    exp_f = f;
    chk("R5 fine word", fine_word, f);
    chk("R7 coarse kept", crs_out(), exp_c);
    chk("R6 fine strobes", n_fu, 1);
    chk("R6 no coarse strobe", n_cu, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    wclk(3);
    chk("R1 reset coarse", crs_out(), 30'd0);
    chk("R1 reset fine", fine_word, 32'd0);
    chk("R1 reset strobes", {crs_upd, fin_upd}, 2'b00);
    rst_n = 1'b1;
    wclk(5);
    chk("R1 after release", {crs_out(), fine_word, crs_upd, fin_upd}, 64'd0);

    run_word(30'h3FFF_FFFF, 32'hFFFF_FFFF);
    run_word(30'h0, 32'h0);
    run_word(30'h2AAA_AAAA, 32'h5555_5555);
    run_word(30'h1555_5555, 32'hAAAA_AAAA);
    // walking ones over each coarse field
    run_word(30'h3C00_0000, 32'h8000_0001);
    run_word(30'h03C0_0000, 32'h0000_0100);
    run_word(30'h003C_0000, 32'h1234_5678);
    run_word(30'h0003_C000, 32'h0F0F_0F0F);
    run_word(30'h0000_3FC0, 32'hF0F0_F0F0);
    run_word(30'h0000_003E, 32'h0001_0000);
    run_word(30'h0000_0001, 32'h8000_0000);
    for (int i = 1; i <= 12; i++) begin
      logic [31:0] h;
      h = i * 32'h9E37_79B9;
      run_word(h[29:0] ^ 30'h1234_5678, ~h ^ (h << 7));
    end

    // R4: clocks while the coarse latch is high must not shift
    run_word(30'h1357_9BDF, 32'h2468_ACE0);
    crs_ld = 1'b1;
    wclk(10);
    for (int b = 0; b < 6; b++) begin
      crs_din = b[0];
      wclk(10); ser_clk = 1'b1; wclk(10); ser_clk = 1'b0;
    end
    crs_ld = 1'b0;
    wclk(10);
    n_cu = 0;
    pulse_ld(1'b1);
    chk("R4 frozen reload", crs_out(), 30'h1357_9BDF);
    chk("R4 strobe on reload", n_cu, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule